// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small, fully associative translation cache. It holds mappings of varying size. Each slot records a naturally aligned virtual base, a size exponent, a physical base, and three attribute bits: user-accessible, writable and global. A slot covers the power-of-two range that starts at its base. Pages of different sizes can therefore sit side by side, and no separate tag array is needed for each size.

A requester issues one command per cycle. The command can be a lookup, a single-page demap, a full flush, or a flush that spares global mappings. A lookup returns a registered response one cycle later. The response gives hit or miss, the physical address and a permission-fault code. Refills come in through a separate insert port, which may fire in the same cycle as any command. Replacement uses a per-slot age rank. Free slots are taken first, and the oldest slot is replaced only when none is free. Walking page tables and delivering faults belong to the surrounding logic. A miss is only reported.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup (`cmd_i`=1) hits a valid slot when base <= `va_i` < base + 2^`lgsz`. `rsp_vld_o` and `rsp_hit_o` appear in the cycle after the command. `rsp_vld_o` is 0 for every other command.
- R2: On a hit, `rsp_pa_o` equals the slot's physical base ORed with `va_i` AND (2^`lgsz` - 1). On a miss, `rsp_pa_o` is 0.
- R3: An access counts as user mode when `priv_i` is 3 and `force_sup_i` is 0. A hit raises a fault in two cases: a user-mode access to a slot without the user bit, or a write (`acc_i`=1; 0 is read, 2 is fetch) to a slot without the writable bit.
- R4: With `store_chk_i` set, a hit on a non-writable slot faults exactly as a write would, whatever `acc_i` holds.
- R5: `rsp_fcode_o` is {present=1, write flag, user flag} while `rsp_fault_o` is 1. The write flag is `acc_i`=1 or `store_chk_i`. The user flag is the R3 user-mode flag. `rsp_fcode_o` is 0 whenever no fault is reported. A miss never faults.
- R6: An insert fills the lowest-index free slot. When every slot is valid, it replaces the least recently used one. The inserted slot becomes the most recently used.
- R7: A hitting lookup with `touch_i`=1 makes that slot the most recently used. With `touch_i`=0, recency is left unchanged.
- R8: A demap (`cmd_i`=2) frees the slot that covers `va_i` and leaves recency unchanged.
- R9: Flush-all (`cmd_i`=3) frees every slot.
- R10: Flush-local (`cmd_i`=4) frees only the slots whose global bit is 0.
- R11: When a command and an insert arrive in the same cycle, the command acts on the old contents first. The insert is applied afterwards, and its victim choice sees the command's effect.
- R12: After reset, every slot is free, every lookup misses, and `rsp_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | 0 idle, 1 lookup, 2 demap, 3 flush-all, 4 flush-local |
| va_i | input | VA_W | Virtual address for lookup or demap |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| priv_i | input | 2 | Privilege level of the access |
| force_sup_i | input | 1 | Treat the access as supervisor |
| store_chk_i | input | 1 | Check write permission on a read |
| touch_i | input | 1 | Update recency on a hit |
| ins_en_i | input | 1 | Insert a mapping this cycle |
| ins_vbase_i | input | VA_W | Virtual base of the new mapping |
| ins_lgsz_i | input | SZ_W | log2 of the mapping size |
| ins_pbase_i | input | PA_W | Physical base of the new mapping |
| ins_user_i | input | 1 | User-accessible attribute |
| ins_wr_i | input | 1 | Writable attribute |
| ins_glob_i | input | 1 | Global attribute |
| rsp_vld_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_pa_o | output | PA_W | Translated physical address |
| rsp_fault_o | output | 1 | Permission fault |
| rsp_fcode_o | output | 3 | Fault code {present, write, user} |

## Verification
An insert can coincide with a lookup that touches a slot, with a demap, or with either flush. Each of these cases decides which slot the insert claims. The bench fills every slot and then issues a touching lookup on the oldest slot in the same cycle as an insert. The touch must save that slot and send the eviction to the next-oldest slot. It also pairs a flush-all with an insert, after which only the new mapping may hit. The outcome is judged by follow-up lookups: which addresses still hit shows where the insert landed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE        = 3'd0,
        CMD_LOOKUP      = 3'd1,
        CMD_DEMAP       = 3'd2,
        CMD_FLUSH_ALL   = 3'd3,
        CMD_FLUSH_LOCAL = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    localparam logic [1:0] PRIV_USER = 2'd3;

endpackage

// File: rtl/xlat_range_match.sv
module xlat_range_match #(
    parameter int N     = 4,
    parameter int VA_W  = 16,
    parameter int SZ_W  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]            vld_i,
    input  logic [N-1:0][VA_W-1:0]  base_i,
    input  logic [N-1:0][SZ_W-1:0]  lg_i,
    input  logic [VA_W-1:0]         va_i,
    output logic [N-1:0]            hit_vec_o,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);

    // Bases are stored aligned, so masking the low bits tests the range.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VA_W-1:0] hi_mask;
        assign hi_mask      = {VA_W{1'b1}} << lg_i[g];
        assign hit_vec_o[g] = vld_i[g] && ((va_i & hi_mask) == base_i[g]);
    end

    assign hit_o = |hit_vec_o;

    // Lowest index wins if software ever installs overlapping ranges.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_age_promote.sv
module xlat_age_promote #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0][W-1:0] age_i,
    input  logic                en_i,
    input  logic [W-1:0]        idx_i,
    output logic [N-1:0][W-1:0] age_o
);

    logic [W-1:0] sel_age;

    // Age 0 is most recent; ages form a permutation of 0..N-1.
    always_comb begin
        age_o   = age_i;
        sel_age = age_i[idx_i];
        if (en_i) begin
            for (int i = 0; i < N; i++) begin
                if (age_i[i] < sel_age) age_o[i] = age_i[i] + 1'b1;
            end
            age_o[idx_i] = '0;
        end
    end

endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0]        vld_i,
    input  logic [N-1:0][W-1:0] age_i,
    output logic [W-1:0]        idx_o
);

    localparam logic [W-1:0] OLDEST = W'(N - 1);

    logic found;

    always_comb begin
        idx_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && !vld_i[i]) begin
                idx_o = W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age_i[i] == OLDEST) idx_o = W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int VA_W    = 16,
    parameter int PA_W    = 16,
    parameter int SZ_W    = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [2:0]      cmd_i,
    input  logic [VA_W-1:0] va_i,
    input  logic [1:0]      acc_i,
    input  logic [1:0]      priv_i,
    input  logic            force_sup_i,
    input  logic            store_chk_i,
    input  logic            touch_i,
    input  logic            ins_en_i,
    input  logic [VA_W-1:0] ins_vbase_i,
    input  logic [SZ_W-1:0] ins_lgsz_i,
    input  logic [PA_W-1:0] ins_pbase_i,
    input  logic            ins_user_i,
    input  logic            ins_wr_i,
    input  logic            ins_glob_i,
    output logic            rsp_vld_o,
    output logic            rsp_hit_o,
    output logic [PA_W-1:0] rsp_pa_o,
    output logic            rsp_fault_o,
    output logic [2:0]      rsp_fcode_o
);

    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        logic [NUM_ENT-1:0]            vld;
        logic [NUM_ENT-1:0]            usr;
        logic [NUM_ENT-1:0]            wr;
        logic [NUM_ENT-1:0]            glob;
        logic [NUM_ENT-1:0][VA_W-1:0]  vbase;
        logic [NUM_ENT-1:0][PA_W-1:0]  pbase;
        logic [NUM_ENT-1:0][SZ_W-1:0]  lg;
        logic [NUM_ENT-1:0][IDX_W-1:0] age;
        logic                          rvld;
        logic                          rhit;
        logic                          rfault;
        logic [PA_W-1:0]               rpa;
        logic [2:0]                    rfc;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_ENT-1:0]            hit_vec;
    logic                          hit_any;
    logic [IDX_W-1:0]              hit_idx;
    logic                          touch_en;
    logic [NUM_ENT-1:0][IDX_W-1:0] age_mid;
    logic [NUM_ENT-1:0][IDX_W-1:0] age_fin;
    logic [NUM_ENT-1:0]            vld_mid;
    logic [IDX_W-1:0]              victim;
    logic                          is_lookup;
    logic                          is_user;
    logic                          wflag;
    logic                          fault;
    logic [VA_W-1:0]               lo_mask;

    xlat_range_match #(
        .N(NUM_ENT), .VA_W(VA_W), .SZ_W(SZ_W), .IDX_W(IDX_W)
    ) u_match (
        .vld_i    (s_q.vld),
        .base_i   (s_q.vbase),
        .lg_i     (s_q.lg),
        .va_i     (va_i),
        .hit_vec_o(hit_vec),
        .hit_o    (hit_any),
        .idx_o    (hit_idx)
    );

    assign is_lookup = (cmd_i == CMD_LOOKUP);
    assign touch_en  = is_lookup && hit_any && touch_i;

    // Step 1: the command's recency effect.
    xlat_age_promote #(.N(NUM_ENT), .W(IDX_W)) u_touch (
        .age_i(s_q.age),
        .en_i (touch_en),
        .idx_i(hit_idx),
        .age_o(age_mid)
    );

    // Step 1: the command's effect on occupancy.
    always_comb begin
        vld_mid = s_q.vld;
        case (cmd_i)
            CMD_DEMAP:       if (hit_any) vld_mid[hit_idx] = 1'b0;
            CMD_FLUSH_ALL:   vld_mid = '0;
            CMD_FLUSH_LOCAL: vld_mid = s_q.vld & s_q.glob;
            default:         vld_mid = s_q.vld;
        endcase
    end

    // Step 2: the insert sees the state left by step 1.
    xlat_victim_pick #(.N(NUM_ENT), .W(IDX_W)) u_victim (
        .vld_i(vld_mid),
        .age_i(age_mid),
        .idx_o(victim)
    );

    xlat_age_promote #(.N(NUM_ENT), .W(IDX_W)) u_fill (
        .age_i(age_mid),
        .en_i (ins_en_i),
        .idx_i(victim),
        .age_o(age_fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.vld  = vld_mid;
        s_d.age  = age_fin;

        is_user  = (priv_i == PRIV_USER) && !force_sup_i;
        wflag    = (acc_i == ACC_WRITE) || store_chk_i;
        fault    = is_lookup && hit_any &&
                   ((is_user && !s_q.usr[hit_idx]) || (wflag && !s_q.wr[hit_idx]));
        lo_mask  = ~({VA_W{1'b1}} << s_q.lg[hit_idx]);

        s_d.rvld   = is_lookup;
        s_d.rhit   = is_lookup && hit_any;
        s_d.rfault = fault;
        s_d.rfc    = fault ? {1'b1, wflag, is_user} : 3'b000;
        s_d.rpa    = (is_lookup && hit_any)
                   ? (s_q.pbase[hit_idx] | PA_W'(va_i & lo_mask)) : '0;

        if (ins_en_i) begin
            s_d.vld[victim]   = 1'b1;
            s_d.usr[victim]   = ins_user_i;
            s_d.wr[victim]    = ins_wr_i;
            s_d.glob[victim]  = ins_glob_i;
            s_d.lg[victim]    = ins_lgsz_i;
            s_d.vbase[victim] = ins_vbase_i & ({VA_W{1'b1}} << ins_lgsz_i);
            s_d.pbase[victim] = ins_pbase_i & ({PA_W{1'b1}} << ins_lgsz_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
            for (int i = 0; i < NUM_ENT; i++) s_q.age[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_vld_o   = s_q.rvld;
    assign rsp_hit_o   = s_q.rhit;
    assign rsp_pa_o    = s_q.rpa;
    assign rsp_fault_o = s_q.rfault;
    assign rsp_fcode_o = s_q.rfc;

    assert_fault_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_fault_o |-> (rsp_fcode_o[2] && rsp_hit_o && rsp_vld_o));

    assert_no_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_fault_o |-> (rsp_fcode_o == 3'b000));

    assert_ins_mru_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_en_i |=> (s_q.vld[$past(victim)] && (s_q.age[$past(victim)] == '0)));

    assert_touch_mru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_lookup && touch_i && hit_any && !ins_en_i) |=> (s_q.age[$past(hit_idx)] == '0));

    assert_peek_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_lookup && !touch_i && !ins_en_i) |=> $stable(s_q.age));

    assert_demap_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_i == CMD_DEMAP) && hit_any && !ins_en_i) |=>
            (!s_q.vld[$past(hit_idx)] && $stable(s_q.age)));

    assert_flush_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_i == CMD_FLUSH_ALL) && !ins_en_i) |=> (s_q.vld == '0));

    assert_flush_local_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_i == CMD_FLUSH_LOCAL) && !ins_en_i) |=> ((s_q.vld & ~s_q.glob) == '0));

endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;

    localparam int N    = 4;
    localparam int VA_W = 16;
    localparam int PA_W = 16;
    localparam int SZ_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cmd = '0;
    logic [VA_W-1:0] va = '0;
    logic [1:0]      acc = '0;
    logic [1:0]      priv = '0;
    logic            fsup = 1'b0;
    logic            schk = 1'b0;
    logic            touch = 1'b0;
    logic            ins_en = 1'b0;
    logic [VA_W-1:0] ins_vb = '0;
    logic [SZ_W-1:0] ins_lg = '0;
    logic [PA_W-1:0] ins_pb = '0;
    logic            ins_u = 1'b0;
    logic            ins_w = 1'b0;
    logic            ins_g = 1'b0;
    logic            rsp_vld, rsp_hit, rsp_fault;
    logic [PA_W-1:0] rsp_pa;
    logic [2:0]      rsp_fc;

    int checks = 0;
    int errors = 0;

    int m_vld[N], m_base[N], m_lg[N], m_pb[N], m_u[N], m_w[N], m_g[N], m_age[N];

    xlat_buffer #(.NUM_ENT(N), .VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_xlat_buffer (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .va_i(va), .acc_i(acc),
        .priv_i(priv), .force_sup_i(fsup), .store_chk_i(schk), .touch_i(touch),
        .ins_en_i(ins_en), .ins_vbase_i(ins_vb), .ins_lgsz_i(ins_lg),
        .ins_pbase_i(ins_pb), .ins_user_i(ins_u), .ins_wr_i(ins_w),
        .ins_glob_i(ins_g), .rsp_vld_o(rsp_vld), .rsp_hit_o(rsp_hit),
        .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_fcode_o(rsp_fc)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input int a);
        for (int i = 0; i < N; i++)
            if (m_vld[i] != 0 && ((a >> m_lg[i]) == (m_base[i] >> m_lg[i]))) return i;
        return -1;
    endfunction

    function automatic void m_promote(input int k);
        int old = m_age[k];
        for (int i = 0; i < N; i++) if (m_age[i] < old) m_age[i]++;
        m_age[k] = 0;
    endfunction

    // Called at a negedge; returns at the next negedge after checking.
    task automatic apply(input int c, input int a, input int ac, input int pv,
                         input int fs, input int sc, input int tc, input int ie,
                         input int vb, input int lg, input int pb,
                         input int iu, input int iw, input int ig);
        int h, user, wf, f, exp_fc, exp_pa, vic;
        cmd = 3'(c); va = 16'(a); acc = 2'(ac); priv = 2'(pv);
        fsup = 1'(fs); schk = 1'(sc); touch = 1'(tc);
        ins_en = 1'(ie); ins_vb = 16'(vb); ins_lg = 4'(lg); ins_pb = 16'(pb);
        ins_u = 1'(iu); ins_w = 1'(iw); ins_g = 1'(ig);
        h      = (c == 1 || c == 2) ? m_find(a) : -1;
        user   = (pv == 3 && fs == 0) ? 1 : 0;
        wf     = (ac == 1 || sc != 0) ? 1 : 0;
        f      = (c == 1 && h >= 0 &&
                  ((user != 0 && m_u[h] == 0) || (wf != 0 && m_w[h] == 0))) ? 1 : 0;
        exp_fc = f ? (4 + 2 * wf + user) : 0;
        exp_pa = (c == 1 && h >= 0) ? (m_pb[h] | (a & ((1 << m_lg[h]) - 1))) : 0;
        if (c == 1 && h >= 0 && tc != 0) m_promote(h);
        if (c == 2 && h >= 0) m_vld[h] = 0;
        if (c == 3) for (int i = 0; i < N; i++) m_vld[i] = 0;
        if (c == 4) for (int i = 0; i < N; i++) if (m_g[i] == 0) m_vld[i] = 0;
        if (ie != 0) begin
            vic = -1;
            for (int i = 0; i < N; i++) if (vic < 0 && m_vld[i] == 0) vic = i;
            if (vic < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) vic = i;
            m_vld[vic] = 1; m_lg[vic] = lg;
            m_base[vic] = vb & ~((1 << lg) - 1);
            m_pb[vic] = pb & ~((1 << lg) - 1);
            m_u[vic] = iu; m_w[vic] = iw; m_g[vic] = ig;
            m_promote(vic);
        end
        @(negedge clk);
        if (c == 1) begin
            chk(rsp_vld == 1'b1, "R1", "valid", int'(rsp_vld), 1);
            chk(rsp_hit == (h >= 0), "R1", "hit", int'(rsp_hit), int'(h >= 0));
            chk(int'(rsp_pa) == exp_pa, "R2", "paddr", int'(rsp_pa), exp_pa);
            chk(int'(rsp_fault) == f, (sc != 0) ? "R4" : "R3", "fault",
                int'(rsp_fault), f);
            chk(int'(rsp_fc) == exp_fc, "R5", "fcode", int'(rsp_fc), exp_fc);
        end else begin
            chk(rsp_vld == 1'b0, "R1", "valid idle", int'(rsp_vld), 0);
        end
        cmd = '0; ins_en = 1'b0;
    endtask

    task automatic ins(input int vb, input int lg, input int pb,
                       input int iu, input int iw, input int ig);
        apply(0, 0, 0, 0, 0, 0, 0, 1, vb, lg, pb, iu, iw, ig);
    endtask

    task automatic look(input int a, input int tc);
        apply(1, a, 0, 0, 0, 0, tc, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_hit(input int a, input bit e, input string req);
        look(a, 0);
        chk(rsp_hit == e, req, "directed hit", int'(rsp_hit), int'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_age[i] = i; m_base[i] = 0; m_lg[i] = 0;
            m_pb[i] = 0; m_u[i] = 0; m_w[i] = 0; m_g[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(rsp_vld == 1'b0, "R12", "reset valid", int'(rsp_vld), 0);
        expect_hit(16'h0000, 1'b0, "R12");
        expect_hit(16'h9abc, 1'b0, "R12");

        // Mixed sizes: 4K, 8K, 1K, 32K
        ins(16'h0000, 12, 16'h8000, 1, 1, 0);
        ins(16'h2000, 13, 16'h4000, 0, 1, 1);
        ins(16'h4000, 10, 16'ha400, 1, 0, 0);
        ins(16'h8000, 15, 16'h0000, 1, 1, 1);

        // R1 R2 R3 R4 R5: address sweep with rotating access attributes
        for (int k = 0; k * 37 < 65536; k++) begin
            int cb = k % 24;
            apply(1, k * 37, cb % 3, ((cb / 3) % 2) * 3, (cb / 6) % 2, (cb / 12) % 2,
                  k % 2, 0, 0, 0, 0, 0, 0, 0);
        end
        // R3 R4: every attribute combination on each page
        for (int p = 0; p < 4; p++) begin
            for (int cb = 0; cb < 24; cb++) begin
                int addrs[4] = '{16'h0123, 16'h3456, 16'h4321, 16'hc001};
                apply(1, addrs[p], cb % 3, ((cb / 3) % 2) * 3, (cb / 6) % 2,
                      (cb / 12) % 2, 0, 0, 0, 0, 0, 0, 0, 0);
            end
        end

        // R7: set order A newest, 32K page oldest; a peek does not refresh
        look(16'h8000, 1); look(16'h4000, 1); look(16'h2000, 1); look(16'h0000, 1);
        look(16'h8000, 0);
        // R6: full buffer, insert replaces the oldest (32K page)
        ins(16'h1000, 12, 16'h3000, 1, 1, 0);
        expect_hit(16'h9000, 1'b0, "R6");
        expect_hit(16'h1234, 1'b1, "R6");
        expect_hit(16'h4000, 1'b1, "R7");

        // R8: demap frees the 8K page; next insert uses that free slot
        apply(2, 16'h2100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_hit(16'h2100, 1'b0, "R8");
        ins(16'h6000, 13, 16'h6000, 1, 1, 1);
        expect_hit(16'h4000, 1'b1, "R8");
        expect_hit(16'h7fff, 1'b1, "R6");

        // R11: touching the oldest slot while inserting moves the eviction
        apply(1, 16'h4010, 0, 0, 0, 0, 1, 1, 16'h8000, 12, 16'hf000, 1, 1, 0);
        expect_hit(16'h0100, 1'b0, "R11");
        expect_hit(16'h4010, 1'b1, "R11");
        expect_hit(16'h8abc, 1'b1, "R11");

        // R11: flush-all with an insert leaves only the new mapping
        apply(3, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 12, 16'h5000, 1, 1, 0);
        expect_hit(16'h0fff, 1'b1, "R11");
        expect_hit(16'h1000, 1'b0, "R11");
        expect_hit(16'h6000, 1'b0, "R9");

        // R10: flush-local keeps only the global mappings
        ins(16'h2000, 13, 16'h2000, 1, 1, 1);
        ins(16'h8000, 15, 16'h8000, 1, 0, 1);
        apply(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_hit(16'h0010, 1'b0, "R10");
        expect_hit(16'h2010, 1'b1, "R10");
        expect_hit(16'hfff0, 1'b1, "R10");

        // R9: flush-all empties the buffer
        apply(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_hit(16'h2010, 1'b0, "R9");
        expect_hit(16'hfff0, 1'b0, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule